// File: doc/BRIEF.md
# Program counter and call stack controller

This block owns the 8-bit instruction address and a downward-growing stack held in a 256-byte data memory. A surrounding core hands it one command per cycle: advance, jump, jump when a tested register is zero, call, return, push or pop. The block updates its program counter and stack pointer and drives the address, write data and write enable of a synchronous RAM port. Both registers are exposed so a register file can read them. Fetch, decode and arithmetic are handled elsewhere.

The stack pointer names the next free slot. Call and push write at the pointer and then move it down. Pop and return read at the pointer plus one and then move it up. A synchronous RAM returns read data one cycle after the address, so pop and return take two cycles. During the second cycle `busy` is high, and any command presented then is dropped. Pop delivers its byte on `pop_data` with `pop_valid` in that second cycle.

Top module: `pcs_ctrl`

## Requirements
- R1: After reset the program counter is 0, the stack pointer is 248, and `busy` and `mem_we` are low.
- R2: Command code 3'b000 (step) adds one to the program counter on the next edge, and 255 becomes 0.
- R3: Command code 3'b001 (jump) loads `cmd_target` into the program counter.
- R4: Command code 3'b010 (jump if zero) loads `cmd_target` when `cmd_operand` is 0 and otherwise adds one to the program counter.
- R5: Command code 3'b011 (call) writes program counter plus one to memory at the stack pointer in the same cycle, then the stack pointer drops by one and the program counter takes `cmd_target`.
- R6: Command code 3'b101 (push) writes `cmd_operand` to memory at the stack pointer in the same cycle, then the stack pointer drops by one. The program counter is unchanged.
- R7: Command code 3'b110 (pop) drives address stack pointer plus one in its cycle. In the next cycle `busy` and `pop_valid` are high and `pop_data` holds the stored byte. After that cycle the stack pointer has risen by one and the program counter is unchanged.
- R8: Command code 3'b100 (return) reads in the same two phases as pop. After the second cycle the program counter holds the stored byte and the stack pointer has risen by one.
- R9: `busy` lasts exactly one cycle. A command presented while `busy` is high has no effect, and no memory write occurs during it.
- R10: The stack pointer wraps modulo 256 in both directions: a push at 0 gives 255, and a pop at 255 reads address 0 and gives 0.
- R11: Command code 3'b111, or `cmd_valid` low, changes neither register and writes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_target | input | 8 | Jump or call destination |
| cmd_operand | input | 8 | Push byte, or the register value tested by jump-if-zero |
| mem_addr | output | 8 | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after the address |
| pc | output | 8 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Second phase of pop or return; commands are ignored |
| pop_valid | output | 1 | `pop_data` carries a popped byte |
| pop_data | output | 8 | Popped byte |

## Verification
On every cycle the assertions check the program counter after step and call, the stack pointer after push and call, that pop and return raise `busy` in the following cycle for exactly one cycle, and that no write occurs while busy. The bench alone shows the memory contents: that call stores the right return address, that pop and return get back the bytes written earlier in last-in first-out order, the zero test of jump-if-zero, and pointer wrap at both ends of the address space. It also shows that a command dropped during `busy` leaves no trace in memory or in the registers.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_STEP = 3'b000,
    OP_JUMP = 3'b001,
    OP_JZ   = 3'b010,
    OP_CALL = 3'b011,
    OP_RET  = 3'b100,
    OP_PUSH = 3'b101,
    OP_POP  = 3'b110,
    OP_NONE = 3'b111
  } pcs_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CAPT = 1'b1
  } pcs_state_e;
endpackage

// File: rtl/pcs_pc_unit.sv
module pcs_pc_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] pc_q
);
  logic [W-1:0] pc_d;
  logic         pc_en;

  always_comb begin
    pc_en = step_en | load_en;
    if (load_en) pc_d = load_val;
    else         pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end
endmodule

// File: rtl/pcs_sp_unit.sv
module pcs_sp_unit #(
  parameter int          W       = 8,
  parameter logic [7:0]  SP_INIT = 8'd248
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_en,
  input  logic         dec_en,
  output logic [W-1:0] sp_q
);
  localparam logic [W-1:0] RST_VAL = W'(SP_INIT);
  logic [W-1:0] sp_d;
  logic         sp_en;

  always_comb begin
    sp_en = inc_en | dec_en;
    if (inc_en) sp_d = sp_q + 1'b1;
    else        sp_d = sp_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= RST_VAL;
    else if (sp_en) sp_q <= sp_d;
  end
endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
  import pcs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_target,
  input  logic [W-1:0] cmd_operand,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] sp,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  output logic         busy,
  output logic         pop_valid,
  output logic [W-1:0] pop_data,
  output logic         pc_step,
  output logic         pc_load,
  output logic [W-1:0] pc_target,
  output logic         sp_inc,
  output logic         sp_dec
);
  pcs_state_e state_q, state_d;
  logic       is_ret_q, is_ret_d;
  logic       capt_en;
  pcs_op_e    op;
  logic [W-1:0] sp_up, pc_up;

  always_comb begin
    op        = pcs_op_e'(cmd_op);
    sp_up     = sp + 1'b1;
    pc_up     = pc + 1'b1;
    state_d   = state_q;
    is_ret_d  = is_ret_q;
    capt_en   = 1'b0;
    mem_addr  = sp;
    mem_we    = 1'b0;
    mem_wdata = cmd_operand;
    busy      = 1'b0;
    pop_valid = 1'b0;
    pop_data  = mem_rdata;
    pc_step   = 1'b0;
    pc_load   = 1'b0;
    pc_target = cmd_target;
    sp_inc    = 1'b0;
    sp_dec    = 1'b0;
    if (state_q == ST_CAPT) begin
      busy     = 1'b1;
      mem_addr = sp_up;
      sp_inc   = 1'b1;
      state_d  = ST_IDLE;
      capt_en  = 1'b1;
      if (is_ret_q) begin
        pc_load   = 1'b1;
        pc_target = mem_rdata;
      end else begin
        pop_valid = 1'b1;
      end
    end else if (cmd_valid) begin
      case (op)
        OP_STEP: pc_step = 1'b1;
        OP_JUMP: pc_load = 1'b1;
        OP_JZ: begin
          if (cmd_operand == '0) pc_load = 1'b1;
          else                   pc_step = 1'b1;
        end
        OP_CALL: begin
          mem_we    = 1'b1;
          mem_wdata = pc_up;
          sp_dec    = 1'b1;
          pc_load   = 1'b1;
        end
        OP_PUSH: begin
          mem_we = 1'b1;
          sp_dec = 1'b1;
        end
        OP_POP, OP_RET: begin
          mem_addr = sp_up;
          state_d  = ST_CAPT;
          is_ret_d = (op == OP_RET);
          capt_en  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      is_ret_q <= 1'b0;
    end else if (capt_en) begin
      state_q  <= state_d;
      is_ret_q <= is_ret_d;
    end
  end

  // R9
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R9
  busy_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we);
  // R7
  pop_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == OP_POP) |=> (busy && pop_valid));
endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
#(
  parameter int         W       = 8,
  parameter logic [7:0] SP_INIT = 8'd248
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_target,
  input  logic [W-1:0] cmd_operand,
  output logic [W-1:0] mem_addr,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] pc,
  output logic [W-1:0] sp,
  output logic         busy,
  output logic         pop_valid,
  output logic [W-1:0] pop_data
);
  logic [1:0]   rst_sync;
  logic         rst_int_n;
  logic         pc_step, pc_load, sp_inc, sp_dec;
  logic [W-1:0] pc_target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pcs_seq #(.W(W)) i_seq (
    .clk(clk), .rst_n(rst_int_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_target(cmd_target),
    .cmd_operand(cmd_operand), .pc(pc), .sp(sp), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .busy(busy), .pop_valid(pop_valid), .pop_data(pop_data),
    .pc_step(pc_step), .pc_load(pc_load), .pc_target(pc_target),
    .sp_inc(sp_inc), .sp_dec(sp_dec)
  );

  pcs_pc_unit #(.W(W)) i_pc (
    .clk(clk), .rst_n(rst_int_n), .step_en(pc_step), .load_en(pc_load),
    .load_val(pc_target), .pc_q(pc)
  );

  pcs_sp_unit #(.W(W), .SP_INIT(SP_INIT)) i_sp (
    .clk(clk), .rst_n(rst_int_n), .inc_en(sp_inc), .dec_en(sp_dec),
    .sp_q(sp)
  );

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && !busy && cmd_op == OP_STEP) |=> pc == W'($past(pc) + 1'b1));
  // R5
  call_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && !busy && cmd_op == OP_CALL) |=>
      (pc == $past(cmd_target) && sp == W'($past(sp) - 1'b1)));
  // R6
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && !busy && cmd_op == OP_PUSH) |=>
      (sp == W'($past(sp) - 1'b1) && $stable(pc)));
  // R8
  ret_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && !busy && cmd_op == OP_RET) |=> (busy && !pop_valid));
endmodule

// File: tb/test_pcs_ctrl.sv
`timescale 1ns/1ps
module test_pcs_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_target, cmd_operand;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, pc, sp, pop_data;
  logic       mem_we, busy, pop_valid;

  logic [7:0] ram    [256];
  logic [7:0] shadow [256];
  logic [7:0] m_pc, m_sp;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcs_ctrl i_pcs_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .cmd_operand(cmd_operand),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .busy(busy),
    .pop_valid(pop_valid), .pop_data(pop_data)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pc(input logic [2:0] op, input logic [7:0] p,
                                        input logic [7:0] tgt, input logic [7:0] opnd,
                                        input logic [7:0] popped);
    case (op)
      3'b000: return p + 8'd1;
      3'b001: return tgt;
      3'b010: return (opnd == 8'd0) ? tgt : p + 8'd1;
      3'b011: return tgt;
      3'b100: return popped;
      default: return p;
    endcase
  endfunction

  function automatic logic [7:0] exp_sp(input logic [2:0] op, input logic [7:0] s);
    case (op)
      3'b011, 3'b101: return s - 8'd1;
      3'b100, 3'b110: return s + 8'd1;
      default: return s;
    endcase
  endfunction

  // Called at a negedge; returns at a negedge with the command finished.
  task automatic run_cmd(input logic [2:0] op, input logic [7:0] tgt, input logic [7:0] opnd);
    logic [7:0] up, popped;
    up     = m_sp + 8'd1;
    popped = shadow[up];
    cmd_valid = 1'b1; cmd_op = op; cmd_target = tgt; cmd_operand = opnd;
    #1;
    if (op == 3'b011) begin
      check(mem_we && mem_addr == m_sp && mem_wdata == m_pc + 8'd1,
            "R5 call write", {mem_we, mem_addr, mem_wdata}, {1'b1, m_sp, m_pc + 8'd1});
      shadow[m_sp] = m_pc + 8'd1;
    end else if (op == 3'b101) begin
      check(mem_we && mem_addr == m_sp && mem_wdata == opnd,
            "R6 push write", {mem_we, mem_addr, mem_wdata}, {1'b1, m_sp, opnd});
      shadow[m_sp] = opnd;
    end else if (op == 3'b100 || op == 3'b110) begin
      check(!mem_we && mem_addr == up, "R7/R8 read address R10", mem_addr, up);
    end else begin
      check(!mem_we, "R11 R2 R3 R4 no write", mem_we, 0);
    end
    @(negedge clk);
    if (op == 3'b100 || op == 3'b110) begin
      cmd_op = 3'b101; cmd_operand = 8'(~opnd); cmd_target = 8'(~tgt);
      #1;
      check(busy == 1'b1, "R9 busy high", busy, 1);
      check(!mem_we, "R9 no write while busy", mem_we, 0);
      if (op == 3'b110)
        check(pop_valid && pop_data == popped, "R7 pop data", pop_data, popped);
      else
        check(!pop_valid, "R8 no pop_valid on return", pop_valid, 0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    m_pc = exp_pc(op, m_pc, tgt, opnd, popped);
    m_sp = exp_sp(op, m_sp);
    check(pc == m_pc, "R2-R8 pc", pc, m_pc);
    check(sp == m_sp, "R10 sp", sp, m_sp);
    check(!busy, "R9 busy cleared", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      ram[i]    = 8'(i * 37 + 5);
      shadow[i] = 8'(i * 37 + 5);
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'b111;
    cmd_target = 8'd0; cmd_operand = 8'd0;
    repeat (3) @(negedge clk);
    #1;
    check(pc == 8'd0, "R1 reset pc", pc, 0);
    check(sp == 8'd248, "R1 reset sp", sp, 248);
    check(!busy && !mem_we, "R1 reset busy/we", {busy, mem_we}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_pc = 8'd0; m_sp = 8'd248;

    // R3 jump then R2 wrap 255 -> 0
    run_cmd(3'b001, 8'd255, 8'd0);
    run_cmd(3'b000, 8'd0, 8'd0);
    check(pc == 8'd0, "R2 wrap", pc, 0);
    // R4 both outcomes
    run_cmd(3'b010, 8'd40, 8'd3);
    run_cmd(3'b010, 8'd40, 8'd0);
    // R5 call then R8 return
    run_cmd(3'b011, 8'd90, 8'd0);
    run_cmd(3'b101, 8'd0, 8'hA5);
    run_cmd(3'b110, 8'd0, 8'd0);
    run_cmd(3'b100, 8'd0, 8'd0);
    check(pc == 8'd41, "R8 return address", pc, 41);
    // R11 idle command
    run_cmd(3'b111, 8'd7, 8'd7);
    // R10 wrap downward: push until sp passes 0
    while (m_sp != 8'd0) run_cmd(3'b101, 8'd0, 8'($urandom));
    run_cmd(3'b101, 8'd0, 8'h3C);
    check(sp == 8'd255, "R10 wrap down", sp, 255);
    run_cmd(3'b110, 8'd0, 8'd0);
    check(sp == 8'd0, "R10 wrap up", sp, 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      logic [7:0] od;
      op = 3'($urandom);
      od = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom);
      run_cmd(op, 8'($urandom), od);
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule